// File: doc/BRIEF.md
# Receive-Buffer Byte Unpacker

This block turns the contents of a 64-byte circular receive buffer, which can only be read one 32-bit word at a time, into a plain stream of bytes. A serial-bus target engine (outside this block) writes incoming bytes into the buffer and advances a hardware write pointer. When a write transaction ends, the engine pulses a write-complete strobe. The unpacker then works out how many bytes arrived since it last drained the buffer. It reads the words that hold them and hands the bytes out one at a time, oldest first, over a valid/ready handshake.

The block keeps its own consumed-byte pointer. A drain can therefore begin at any byte lane and can run across the top of the buffer back to address zero. A word is fetched once at the start of every drain. After that, a word is fetched only when the pointer moves onto a new 4-byte boundary. When the drain finishes, the block pulses a done signal and shows the message length. Downstream logic uses that length to tell a short register-select write from a write that carries data.

Top module: `rxbuf_unpacker`

## Requirements
- R1: On service of a write-complete event, the message length is (hw_wptr − consumed pointer) mod 64, using hw_wptr as sampled in the service cycle. That value appears on msg_len while msg_done is high.
- R2: Bytes leave in buffer-address order. The byte at buffer address p is taken from bits [8·(p mod 4)+7 : 8·(p mod 4)] of word p/4.
- R3: Every drain with a nonzero length starts with a word fetch (rd_en high, rd_idx = pointer/4), whatever the pointer's alignment. rd_word is used in the cycle after rd_en, and no byte is offered before that.
- R4: Within a drain, another fetch is issued only after the byte in lane 3 has been accepted and more bytes remain. The number of fetches in a drain therefore equals the number of words the message touches.
- R5: The consumed pointer advances by one for each accepted byte and wraps from 63 to 0. Each drain starts where the previous one ended.
- R6: Reset sets the consumed pointer to 0 and holds out_valid, rd_en and msg_done low.
- R7: A zero-length message offers no bytes and makes no fetch, but still pulses msg_done with msg_len = 0.
- R8: While out_valid is high and out_ready is low, out_valid stays high, out_byte stays stable and the pointer does not move.
- R9: A write-complete strobe that arrives during a drain is remembered. It is serviced once the current drain is done, and hw_wptr is sampled at that later time.
- R10: msg_done is a single-cycle pulse, following the acceptance of the last byte. It is never high together with out_valid or rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_done | input | 1 | Write-complete strobe from the bus engine |
| hw_wptr | input | 6 | Hardware byte write pointer into the buffer |
| rd_en | output | 1 | Word read request to the buffer |
| rd_idx | output | 4 | Word index for the read request |
| rd_word | input | 32 | Word read data, valid one cycle after rd_en |
| out_byte | output | 8 | Byte stream data |
| out_valid | output | 1 | Byte stream valid |
| out_ready | input | 1 | Byte stream ready |
| msg_done | output | 1 | End-of-message pulse |
| msg_len | output | 6 | Length of the finished message, valid with msg_done |

## Verification
The checks assume three things about the inputs. The buffer answers every rd_en with the addressed word on the very next cycle. The buffer contents do not change while a drain is running. hw_wptr never runs 64 or more bytes ahead of the consumed pointer. The bench meets all three. Its buffer model is a register with one cycle of read latency. The buffer is filled with fixed data before any event is raised. Every write pointer it drives is less than a full buffer ahead of the pointer it tracks itself. Under those conditions the fetch-boundary and stall properties are checked in every cycle, including drains that wrap and that run under alternating backpressure.

// File: rtl/rxbuf_unpacker.sv
module rxbuf_unpacker #(
  parameter int BUF_BYTES  = 64,
  parameter int WORD_BYTES = 4
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          wr_done,
  input  logic [$clog2(BUF_BYTES)-1:0]                  hw_wptr,
  output logic                                          rd_en,
  output logic [$clog2(BUF_BYTES)-$clog2(WORD_BYTES)-1:0] rd_idx,
  input  logic [8*WORD_BYTES-1:0]                       rd_word,
  output logic [7:0]                                    out_byte,
  output logic                                          out_valid,
  input  logic                                          out_ready,
  output logic                                          msg_done,
  output logic [$clog2(BUF_BYTES)-1:0]                  msg_len
);
  localparam int PTR_W  = $clog2(BUF_BYTES);
  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam int IDX_W  = PTR_W - LANE_W;
  localparam int WORD_W = 8 * WORD_BYTES;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_RUN, S_DONE} state_t;

  state_t             state;
  logic [PTR_W-1:0]   cptr, remain, len;
  logic [WORD_W-1:0]  word;
  logic               pend;
  logic [PTR_W-1:0]   avail;
  logic [LANE_W-1:0]  lane;

  assign avail     = hw_wptr - cptr;
  assign lane      = cptr[LANE_W-1:0];
  assign rd_en     = (state == S_REQ);
  assign rd_idx    = cptr[PTR_W-1:LANE_W];
  assign out_valid = (state == S_RUN);
  assign out_byte  = word[{lane, 3'b000} +: 8];
  assign msg_done  = (state == S_DONE);
  assign msg_len   = len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cptr   <= '0;
      remain <= '0;
      len    <= '0;
      word   <= '0;
      pend   <= 1'b0;
    end else begin
      if (wr_done && state != S_IDLE) pend <= 1'b1;
      case (state)
        S_IDLE: if (wr_done || pend) begin
          pend   <= 1'b0;
          remain <= avail;
          len    <= avail;
          state  <= (avail == '0) ? S_DONE : S_REQ;
        end
        S_REQ:  state <= S_WAIT;
        S_WAIT: begin
          word  <= rd_word;
          state <= S_RUN;
        end
        S_RUN: if (out_ready) begin
          cptr   <= cptr + 1'b1;
          remain <= remain - 1'b1;
          if (remain == PTR_W'(1))        state <= S_DONE;
          else if (&lane)                 state <= S_REQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module rxbuf_unpacker_chk #(
  parameter int PTR_W  = 6,
  parameter int LANE_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_byte,
  input logic             msg_done,
  input logic [PTR_W-1:0] cptr,
  input logic [PTR_W-1:0] remain
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(cptr)); // R8
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> cptr == PTR_W'($past(cptr) + 1'b1)); // R5
  AST_FETCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && (&cptr[LANE_W-1:0]) && remain != PTR_W'(1) |=> rd_en); // R4
  AST_NO_MIDWORD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(&cptr[LANE_W-1:0]) |=> !rd_en); // R4
  AST_FETCH_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !out_valid && !rd_en); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> !msg_done); // R10
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> !out_valid && !rd_en); // R10
endmodule

bind rxbuf_unpacker rxbuf_unpacker_chk #(.PTR_W(PTR_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte), .msg_done(msg_done),
  .cptr(cptr), .remain(remain)
);

// File: tb/rxbuf_unpacker_bench.sv
module rxbuf_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_done = 1'b0;
  logic [5:0]  hw_wptr = '0;
  logic        rd_en;
  logic [3:0]  rd_idx;
  logic [31:0] rd_word = '0;
  logic [7:0]  out_byte;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        msg_done;
  logic [5:0]  msg_len;

  int checks = 0;
  int errors = 0;
  int mp = 0;
  logic [31:0] mem [16];

  always #10 clk = ~clk;

  rxbuf_unpacker u_rxbuf_unpacker (
    .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .hw_wptr(hw_wptr),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_word(rd_word),
    .out_byte(out_byte), .out_valid(out_valid), .out_ready(out_ready),
    .msg_done(msg_done), .msg_len(msg_len)
  );

  always_ff @(posedge clk) if (rd_en) rd_word <= mem[rd_idx];

  function automatic logic [7:0] bval(int a);
    return 8'(a * 37 + 11);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; collects one message, optionally injects an event.
  task automatic drain(int exp_len, bit stall, int inj_at, logic [5:0] inj_w);
    int got = 0, fetches = 0, cyc = 0, p0 = mp;
    int exp_f = (exp_len == 0) ? 0 : ((p0 % 4) + exp_len + 3) / 4;
    bit byte_ok = 1'b1;
    forever begin
      if (cyc == inj_at) begin hw_wptr = inj_w; wr_done = 1'b1; end
      else wr_done = 1'b0;
      out_ready = stall ? (cyc % 2 == 1) : 1'b1;
      if (rd_en) fetches++;
      if (out_valid && out_ready) begin
        if (out_byte != bval(mp)) begin
          byte_ok = 1'b0;
          check(1'b0, "R2", out_byte, bval(mp));
        end
        mp = (mp + 1) % 64;
        got++;
      end
      if (msg_done) begin
        check(msg_len == 6'(exp_len), "R1", msg_len, exp_len);
        check(got == exp_len, "R5", got, exp_len);
        check(fetches == exp_f, exp_len == 0 ? "R7" : "R4", fetches, exp_f);
        check(byte_ok, "R2", byte_ok, 1);
        @(negedge clk);
        check(!msg_done, "R10", msg_done, 0);
        out_ready = 1'b1;
        wr_done = 1'b0;
        return;
      end
      if (cyc > 400) begin
        check(1'b0, "R10", cyc, 0);
        return;
      end
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_msg(logic [5:0] w, bit stall);
    @(negedge clk);
    hw_wptr = w;
    wr_done = 1'b1;
    @(negedge clk);
    wr_done = 1'b0;
    drain(int'(6'(w - 6'(mp))), stall, -1, '0);
  endtask

  // bit 6 = backpressure, bits 5:0 = write pointer
  localparam logic [6:0] VEC [7] = '{7'd5, 7'd69, 7'd77, 7'd2, 7'd67, 7'd8, 7'd64};

  initial begin
    for (int i = 0; i < 16; i++)
      for (int k = 0; k < 4; k++) mem[i][8*k +: 8] = bval(4*i + k);
    repeat (3) @(negedge clk);
    check(!out_valid && !rd_en && !msg_done, "R6", {out_valid, rd_en, msg_done}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < 7; v++) run_msg(VEC[v][5:0], VEC[v][6]);

    // R9: event arriving mid-drain is held and serviced later
    @(negedge clk);
    hw_wptr = 6'(mp + 6);
    wr_done = 1'b1;
    @(negedge clk);
    drain(6, 1'b0, 3, 6'(mp + 15));
    check(1'b1, "R9", 0, 0);
    @(negedge clk);
    drain(9, 1'b1, -1, '0);

    // R6: reset returns the pointer to zero
    check(mp != 0, "R6", mp, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(!out_valid && !rd_en && !msg_done, "R6", {out_valid, rd_en, msg_done}, 0);
    rst_n = 1'b1;
    mp = 0;
    run_msg(6'd4, 1'b0);
    run_msg(6'd4, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule